// File: doc/BRIEF.md
# Partitioned Subword SIMD ALU

A 64-bit ALU that treats its two operands either as one wide word or as a row of packed lanes, and applies one simple operation to every lane in the same pass. A two-bit lane-mode input splits the word into one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. The operation is chosen from bitwise AND, bitwise OR and addition.

Addition does not use one adder per lane. It uses one shared 64-bit adder built from 8-bit chunks. At every chunk boundary that is also a lane boundary for the chosen mode, the carry into the next chunk is forced to zero. Each lane therefore wraps on its own, and the carry out of its top bit is discarded. AND and OR have no carries, so the lane mode has no effect on them.

A parameter selects between two variants. In the default variant the output is registered: a result is captured on the clock edge that sees the input valid signal, and it appears together with an output valid one cycle later. In the other variant the output is the combinational function of the present inputs.

Top module: `lane_alu`

## Requirements
- R1: Operands and result are 64 bits wide. The lane mode is encoded as 00 = one 64-bit lane, 01 = two 32-bit lanes, 10 = four 16-bit lanes and 11 = eight 8-bit lanes. Lane i occupies bits [i*w +: w], where w is the lane width.
- R2: With op code 10 (ADD) in modes 01, 10 and 11, each lane's result equals the sum of the two operand lanes modulo 2^w. No carry passes from one lane into the next.
- R3: With ADD in mode 00, the result is the full 64-bit sum modulo 2^64. All chunk carries propagate, and the final carry out is dropped.
- R4: Op code 00 gives the bitwise AND of the operands, and the result is the same for every lane mode.
- R5: Op code 01 gives the bitwise OR of the operands, and the result is the same for every lane mode.
- R6: Op code 11 is reserved and gives an all-zero result.
- R7: In the registered variant (REG_OUT=1), `res_valid` is high in exactly the cycle after a cycle with `in_valid` high. In that cycle `res` holds the result of the inputs presented with `in_valid`.
- R8: In the registered variant, a cycle with `in_valid` low leaves `res` unchanged on the next edge, whatever the operands, mode and op code.
- R9: While `rst_n` is low, the registered variant drives `res` to zero and `res_valid` to zero.
- R10: In the combinational variant (REG_OUT=0), `res` is the function of the present inputs and `res_valid` equals `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands, mode and op code are valid this cycle |
| opnd_a | input | 64 | First packed operand |
| opnd_b | input | 64 | Second packed operand |
| lane_mode | input | 2 | Lane partition: 00 x64, 01 x32, 10 x16, 11 x8 |
| alu_op | input | 2 | 00 AND, 01 OR, 10 ADD, 11 reserved (zero) |
| res_valid | output | 1 | Result valid |
| res | output | 64 | Packed result |

## Verification
The bench builds two instances with the default 64-bit width and 8-bit chunk: one with REG_OUT=1 and one with REG_OUT=0. Both variants are therefore checked against the same lane-by-lane reference on every clock. Directed all-ones operands plus a per-byte one place a carry at every chunk boundary in each mode, so a boundary that is cut wrongly or left open shows at the output. Random operands with `in_valid` sometimes low then cover the hold behaviour and the reserved op code.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ADD  = 2'b10,
    OP_RSVD = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    LM_X64 = 2'b00,
    LM_X32 = 2'b01,
    LM_X16 = 2'b10,
    LM_X8  = 2'b11
  } lane_mode_e;

  // number of chunks spanned by one lane in a given mode
  function automatic int chunks_per_lane(int nchunk, logic [1:0] mode);
    int span;
    span = nchunk >> mode;
    if (span < 1) span = 1;
    return span;
  endfunction

  // true when chunk k is the lowest chunk of a lane (its carry-in is cut)
  function automatic logic chunk_starts_lane(int k, int nchunk, logic [1:0] mode);
    return (k % chunks_per_lane(nchunk, mode)) == 0;
  endfunction

  // number of lanes for a mode
  function automatic int lanes_in_mode(logic [1:0] mode);
    return 1 << mode;
  endfunction

endpackage

// File: rtl/lane_boundary_dec.sv
module lane_boundary_dec #(
  parameter int NCHUNK = 8
) (
  input  logic [1:0]        lane_mode,
  output logic [NCHUNK-1:0] carry_cut
);
  import lane_alu_pkg::*;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_cut
    assign carry_cut[k] = chunk_starts_lane(k, NCHUNK, lane_mode);
  end

endmodule

// File: rtl/split_adder.sv
module split_adder #(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8
) (
  input  logic [DATA_W-1:0]          a,
  input  logic [DATA_W-1:0]          b,
  input  logic [DATA_W/CHUNK_W-1:0]  carry_cut,
  output logic [DATA_W-1:0]          sum,
  output logic [DATA_W/CHUNK_W-1:0]  chunk_cin
);
  localparam int NCHUNK = DATA_W / CHUNK_W;

  logic [NCHUNK-2:0] chunk_cout;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    if (k == 0) begin : g_first
      assign chunk_cin[k] = 1'b0;
    end else begin : g_next
      assign chunk_cin[k] = carry_cut[k] ? 1'b0 : chunk_cout[k-1];
    end

    if (k == NCHUNK - 1) begin : g_top
      // the top chunk's carry leaves the word and is dropped
      assign sum[k*CHUNK_W +: CHUNK_W] =
        a[k*CHUNK_W +: CHUNK_W] + b[k*CHUNK_W +: CHUNK_W] + CHUNK_W'(chunk_cin[k]);
    end else begin : g_mid
      assign {chunk_cout[k], sum[k*CHUNK_W +: CHUNK_W]} =
        {1'b0, a[k*CHUNK_W +: CHUNK_W]} + {1'b0, b[k*CHUNK_W +: CHUNK_W]}
        + (CHUNK_W+1)'(chunk_cin[k]);
    end
  end

endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sel_or,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    if (sel_or) y = a | b;
    else        y = a & b;
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu #(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [1:0]        lane_mode,
  input  logic [1:0]        alu_op,
  output logic              res_valid,
  output logic [DATA_W-1:0] res
);
  import lane_alu_pkg::*;

  localparam int NCHUNK = DATA_W / CHUNK_W;

  alu_op_e           op_e;
  logic [NCHUNK-1:0] carry_cut;
  logic [NCHUNK-1:0] chunk_cin;
  logic [DATA_W-1:0] add_y;
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] res_comb;
  logic              sel_or;

  assign op_e   = alu_op_e'(alu_op);
  assign sel_or = (op_e == OP_OR);

  lane_boundary_dec #(.NCHUNK(NCHUNK)) u_dec (
    .lane_mode (lane_mode),
    .carry_cut (carry_cut)
  );

  split_adder #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_add (
    .a         (opnd_a),
    .b         (opnd_b),
    .carry_cut (carry_cut),
    .sum       (add_y),
    .chunk_cin (chunk_cin)
  );

  bitwise_unit #(.DATA_W(DATA_W)) u_bit (
    .a      (opnd_a),
    .b      (opnd_b),
    .sel_or (sel_or),
    .y      (logic_y)
  );

  always_comb begin
    unique case (op_e)
      OP_AND, OP_OR: res_comb = logic_y;
      OP_ADD:        res_comb = add_y;
      default:       res_comb = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] res_q;
    logic              vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) res_q <= res_comb;
      end
    end

    assign res       = res_q;
    assign res_valid = vld_q;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid); // R7
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res)); // R8
    AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alu_op == 2'b00) |=> res == ($past(opnd_a) & $past(opnd_b))); // R4
    AST_OR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alu_op == 2'b01) |=> res == ($past(opnd_a) | $past(opnd_b))); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alu_op == 2'b11) |=> res == '0); // R6
  end else begin : g_comb
    assign res       = res_comb;
    assign res_valid = in_valid;
  end

  AST_CUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(carry_cut) == lanes_in_mode(lane_mode)); // R2
  AST_WIDE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'b00) |-> carry_cut[NCHUNK-1:1] == '0); // R3
  AST_LOW_CIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_cin[0] == 1'b0); // R2

endmodule

// File: tb/test_lane_alu.sv
`timescale 1ns/1ps
module test_lane_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [1:0]  lane_mode = '0;
  logic [1:0]  alu_op = '0;
  logic        res_valid_r, res_valid_c;
  logic [63:0] res_r, res_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] exp_res = '0;
  logic        exp_vld = 1'b0;
  string       last_tag = "R9";

  always #4 clk = ~clk;

  lane_alu #(.REG_OUT(1'b1)) i_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .lane_mode(lane_mode), .alu_op(alu_op), .res_valid(res_valid_r), .res(res_r)
  );

  lane_alu #(.REG_OUT(1'b0)) i_lane_alu_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .lane_mode(lane_mode), .alu_op(alu_op), .res_valid(res_valid_c), .res(res_c)
  );

  // lane-by-lane reference written from the requirements
  function automatic logic [63:0] ref_alu(logic [63:0] a, logic [63:0] b,
                                          logic [1:0] mode, logic [1:0] op);
    logic [63:0] r, mask, la, lb;
    int lw;
    r = '0;
    case (op)
      2'b00: r = a & b;
      2'b01: r = a | b;
      2'b10: begin
        lw = 64 >> mode;
        mask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
        for (int l = 0; l < 64 / lw; l++) begin
          la = (a >> (l * lw)) & mask;
          lb = (b >> (l * lw)) & mask;
          r  = r | (((la + lb) & mask) << (l * lw));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] mode, logic [1:0] op);
    case (op)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return (mode == 2'b00) ? "R3" : "R2";
      default: return "R6";
    endcase
  endfunction

  // cycle model of the registered variant
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_res <= '0;
      exp_vld <= 1'b0;
    end else begin
      exp_vld <= in_valid;
      if (in_valid) exp_res <= ref_alu(opnd_a, opnd_b, lane_mode, alu_op);
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [63:0] a, logic [63:0] b,
                      logic [1:0] mode, logic [1:0] op);
    @(negedge clk);
    check(last_tag, res_r, exp_res);
    check("R7", 64'(res_valid_r), 64'(exp_vld));
    in_valid  = v;
    opnd_a    = a;
    opnd_b    = b;
    lane_mode = mode;
    alu_op    = op;
    last_tag  = v ? tag_of(mode, op) : "R8";
    #1;
    check("R10", res_c, ref_alu(a, b, mode, op));
    check("R10", 64'(res_valid_c), 64'(v));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R9", res_r, 64'h0);
    check("R9", 64'(res_valid_r), 64'h0);
    rst_n = 1'b1;

    // carry at every byte boundary, every mode
    for (int m = 0; m < 4; m++) begin
      step(1'b1, {64{1'b1}}, 64'h0101_0101_0101_0101, 2'(m), 2'b10);
      if (m == 3) check("R1", res_c, 64'h0);
      if (m == 2) check("R1", res_c, 64'h0100_0100_0100_0100);
      if (m == 0) check("R3", res_c, 64'h0101_0101_0101_0100);
    end
    for (int m = 0; m < 4; m++) step(1'b1, {64{1'b1}}, 64'h1, 2'(m), 2'b10);
    // logic ops ignore mode
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 64'hF0F0_FF00_1234_8001, 64'h0FF0_F0F0_FFFF_8000, 2'(m), 2'b00);
      check("R4", res_c, 64'h00F0_F000_1234_8000);
      step(1'b1, 64'hF0F0_FF00_1234_8001, 64'h0FF0_F0F0_FFFF_8000, 2'(m), 2'b01);
      check("R5", res_c, 64'hFFF0_FFF0_FFFF_8001);
    end
    step(1'b1, {64{1'b1}}, {64{1'b1}}, 2'b01, 2'b11);
    check("R6", res_c, 64'h0);
    // idle cycles with changing inputs
    step(1'b0, 64'h1234, 64'h5678, 2'b11, 2'b10);
    step(1'b0, 64'hDEAD, 64'hBEEF, 2'b00, 2'b01);

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom},
           2'($urandom), 2'($urandom));
    end
    step(1'b0, '0, '0, 2'b00, 2'b00);
    step(1'b0, '0, '0, 2'b00, 2'b00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule